// File: doc/BRIEF.md
# Grouped Peripheral Interrupt Expander

This block takes a wide bank of peripheral interrupt request lines, arranged as twelve groups of eight, and folds them onto twelve CPU-level interrupt lines. Every source has its own pending flag and enable bit, and every group has an acknowledge bit that blocks the group after one of its sources is serviced. At CPU level, each line has a flag and an enable, and a global mask gates the whole request. When the CPU accepts the request, the block picks one winning source. It returns that source's own vector address, clears the bookkeeping for that source and sets the global mask. It then steps a sequencer through the fixed list of register pairs that the CPU saves on entry.

Software changes state through a single-cycle register-write port. Each write carries a kind code, a group number and a data word. The vector address stays valid while the context-save sequence runs. The sequence is a valid/ready stream. `ctx_valid` rises in the cycle after the CPU accepts the request. The select value holds while `ctx_ready` is low. The select advances once for each cycle in which valid and ready are both high. Valid falls after the seventh pair is accepted, and no new interrupt is offered to the CPU while the sequence is busy.

Top module: `grp_irq_expander`

## Requirements
- R1: After reset all source flags, source enables, group acknowledges, line flags and line enables are clear. The expander is disabled, the global mask is set, and `cpu_irq`, `vec_valid` and `ctx_valid` are low.
- R2: A source flag is set in the clock after its request line is high and stays set after the request falls. If the same source's flag is being cleared in the same clock, the set wins.
- R3: `cpu_irq` is high while a line has both its flag and enable set, the global mask is clear and no context sequence is running. A line flag is set one clock after its group holds an enabled pending source and the group is not acknowledged. `cpu_irq` therefore rises two clocks after the request edge.
- R4: Among lines, the lower line number wins. Within a group, the lower source index wins. Source s belongs to line s/8 with index s%8.
- R5: On a take (`cpu_irq` and `cpu_ack` both high at a clock), `vec_addr` loads on that clock. With the expander enabled it loads SRC_BASE + 2*(line*8+index), and it holds while `vec_valid` is high. With the expander disabled it loads LINE_BASE + 2*(line+1).
- R6: A take with the expander enabled clears the winning source flag, clears the winning line flag and sets that group's acknowledge. While the acknowledge is set, the group raises no request.
- R7: A take sets the global mask. Only a control write clears it.
- R8: After a take, `ctx_sel` runs through the codes 0 to 6 in this order: status/temp, accumulator, product, pointers 0/1, status/page, enable/debug, program counter. It advances only when `ctx_valid` and `ctx_ready` are both high, and it holds otherwise.
- R9: Write kinds: 0 loads the source enables of group `wr_grp` from `wr_data[7:0]`. 1 clears the group acknowledges where a `wr_data` bit is 1. 2 loads the line enables from `wr_data[11:0]`. 3 clears the line flags where a bit is 1. 4 writes control, with bit 0 as expander enable and bit 1 as global mask. 5 clears the source flags of group `wr_grp` where a bit of `wr_data[7:0]` is 1.
- R10: A take with the expander disabled leaves the source flag and the group acknowledge untouched, so the same source is still pending afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| irq_req | input | 96 | Peripheral request lines, source s at bit s |
| wr_en | input | 1 | Register write strobe |
| wr_kind | input | 3 | Write kind code |
| wr_grp | input | 4 | Group selected by the write |
| wr_data | input | 12 | Write data |
| cpu_ack | input | 1 | CPU accepts the pending request |
| cpu_irq | output | 1 | Interrupt request to the CPU |
| vec_valid | output | 1 | Vector address valid |
| vec_addr | output | 22 | Vector address of the serviced source |
| ctx_valid | output | 1 | Context-save select valid |
| ctx_ready | input | 1 | CPU has saved the current pair |
| ctx_sel | output | 3 | Register pair to save |

## Verification
Two events can land on the same source flag in one clock. A take clears the flag of the winning source, and that source's request line can set the flag at the same edge. The bench holds the request of one source high across the acknowledge clock. It then clears the group acknowledge and the mask without raising the request again. A second `cpu_irq` that carries the same vector shows that the set won. The bench also gives three sources on two lines the same request edge. The vectors it gets back must follow the line and index order.

// File: rtl/gie_pkg.sv
package gie_pkg;
  typedef enum logic [2:0] {
    WK_SRC_EN        = 3'd0,
    WK_GRP_ACK_CLR   = 3'd1,
    WK_LINE_EN       = 3'd2,
    WK_LINE_FLAG_CLR = 3'd3,
    WK_CTRL          = 3'd4,
    WK_SRC_FLAG_CLR  = 3'd5
  } wr_kind_e;

  typedef enum logic [2:0] {
    PAIR_STAT_TMP  = 3'd0,
    PAIR_ACC       = 3'd1,
    PAIR_PROD      = 3'd2,
    PAIR_PTR01     = 3'd3,
    PAIR_STAT_PAGE = 3'd4,
    PAIR_IEN_DBG   = 3'd5,
    PAIR_PC        = 3'd6
  } ctx_pair_e;

  localparam int unsigned CTX_STEPS = 7;
endpackage

// File: rtl/gie_prio.sv
module gie_prio #(
  parameter int unsigned N = 8,
  parameter int unsigned W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0] vec,
  output logic         any,
  output logic [W-1:0] idx
);
  always_comb begin
    any = |vec;
    idx = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (vec[k]) idx = W'(k);
    end
  end
endmodule

// File: rtl/gie_group.sv
module gie_group #(
  parameter int unsigned SRC_N = 8,
  parameter int unsigned IDX_W = $clog2(SRC_N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_N-1:0] req,
  input  logic             en_we,
  input  logic [SRC_N-1:0] en_wdata,
  input  logic             fclr_we,
  input  logic [SRC_N-1:0] fclr_mask,
  input  logic             ack_clr,
  input  logic             take,
  input  logic [IDX_W-1:0] take_idx,
  output logic             pend,
  output logic [IDX_W-1:0] win_idx,
  output logic             ack_o
);
  logic [SRC_N-1:0] flag_q, en_q, clr, live;
  logic             ack_q, live_any;

  always_comb begin
    clr = fclr_we ? fclr_mask : '0;
    if (take) clr[take_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      en_q   <= '0;
      ack_q  <= 1'b0;
    end else begin
      flag_q <= (flag_q & ~clr) | req;
      if (en_we) en_q <= en_wdata;
      if (take) ack_q <= 1'b1;
      else if (ack_clr) ack_q <= 1'b0;
    end
  end

  assign live = flag_q & en_q;

  gie_prio #(.N(SRC_N), .W(IDX_W)) u_src_prio (
    .vec(live), .any(live_any), .idx(win_idx)
  );

  assign pend  = live_any & ~ack_q;
  assign ack_o = ack_q;

  AST_TAKE_CLEARS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    take && !req[take_idx] |=> !flag_q[$past(take_idx)]); // R6
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    take && req[take_idx] |=> flag_q[$past(take_idx)]); // R2
  AST_TAKE_SETS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> ack_q && !pend); // R6
endmodule

// File: rtl/gie_ctx_seq.sv
module gie_ctx_seq #(
  parameter int unsigned STEPS = 7,
  parameter int unsigned SEL_W = $clog2(STEPS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             ready,
  output logic             valid,
  output logic [SEL_W-1:0] sel
);
  localparam logic [SEL_W-1:0] LAST = SEL_W'(STEPS - 1);
  logic             busy_q;
  logic [SEL_W-1:0] step_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      step_q <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      step_q <= '0;
    end else if (busy_q && ready) begin
      if (step_q == LAST) busy_q <= 1'b0;
      else step_q <= step_q + 1'b1;
    end
  end

  assign valid = busy_q;
  assign sel   = step_q;

  AST_CTX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !ready |=> valid && $stable(sel)); // R8
  AST_CTX_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    valid && ready && sel != LAST |=> valid && sel == $past(sel) + 1'b1); // R8
  AST_CTX_START: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> valid && sel == '0); // R8
endmodule

// File: rtl/grp_irq_expander.sv
module grp_irq_expander #(
  parameter int unsigned GROUPS    = 12,
  parameter int unsigned PER_GRP   = 8,
  parameter int unsigned ADDR_W    = 22,
  parameter logic [21:0] SRC_BASE  = 22'h000D00,
  parameter logic [21:0] LINE_BASE = 22'h3FFFC0
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [GROUPS*PER_GRP-1:0]     irq_req,
  input  logic                          wr_en,
  input  logic [2:0]                    wr_kind,
  input  logic [$clog2(GROUPS)-1:0]     wr_grp,
  input  logic [GROUPS-1:0]             wr_data,
  input  logic                          cpu_ack,
  output logic                          cpu_irq,
  output logic                          vec_valid,
  output logic [ADDR_W-1:0]             vec_addr,
  output logic                          ctx_valid,
  input  logic                          ctx_ready,
  output logic [$clog2(gie_pkg::CTX_STEPS)-1:0] ctx_sel
);
  import gie_pkg::*;

  localparam int unsigned GRP_W = $clog2(GROUPS);
  localparam int unsigned IDX_W = $clog2(PER_GRP);
  localparam int unsigned SEL_W = $clog2(CTX_STEPS);
  localparam logic [ADDR_W-1:0] PER_GRP_A = ADDR_W'(PER_GRP);

  wr_kind_e          kind;
  logic [GROUPS-1:0] line_flag_q, line_en_q, line_clr, pend_vec, grp_ack, eligible;
  logic              gmask_q, pie_en_q, line_any, take, busy;
  logic [GRP_W-1:0]  line_sel;
  logic [IDX_W-1:0]  grp_win [GROUPS];
  logic [IDX_W-1:0]  sel_idx;
  logic [ADDR_W-1:0] vec_q;

  assign kind = wr_kind_e'(wr_kind);

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    gie_group #(.SRC_N(PER_GRP), .IDX_W(IDX_W)) u_grp (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (irq_req[g*PER_GRP +: PER_GRP]),
      .en_we     (wr_en && kind == WK_SRC_EN && wr_grp == GRP_W'(g)),
      .en_wdata  (wr_data[PER_GRP-1:0]),
      .fclr_we   (wr_en && kind == WK_SRC_FLAG_CLR && wr_grp == GRP_W'(g)),
      .fclr_mask (wr_data[PER_GRP-1:0]),
      .ack_clr   (wr_en && kind == WK_GRP_ACK_CLR && wr_data[g]),
      .take      (take && pie_en_q && line_sel == GRP_W'(g)),
      .take_idx  (grp_win[g]),
      .pend      (pend_vec[g]),
      .win_idx   (grp_win[g]),
      .ack_o     (grp_ack[g])
    );
  end

  assign eligible = line_flag_q & line_en_q;

  gie_prio #(.N(GROUPS), .W(GRP_W)) u_line_prio (
    .vec(eligible), .any(line_any), .idx(line_sel)
  );

  assign sel_idx = grp_win[line_sel];
  assign cpu_irq = line_any & ~gmask_q & ~busy;
  assign take    = cpu_irq & cpu_ack;

  always_comb begin
    line_clr = (wr_en && kind == WK_LINE_FLAG_CLR) ? wr_data : '0;
    if (take) line_clr[line_sel] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_flag_q <= '0;
      line_en_q   <= '0;
      gmask_q     <= 1'b1;
      pie_en_q    <= 1'b0;
      vec_q       <= '0;
    end else begin
      line_flag_q <= (line_flag_q | pend_vec) & ~line_clr;
      if (wr_en && kind == WK_LINE_EN) line_en_q <= wr_data;
      if (wr_en && kind == WK_CTRL) pie_en_q <= wr_data[0];
      if (take) gmask_q <= 1'b1;
      else if (wr_en && kind == WK_CTRL) gmask_q <= wr_data[1];
      if (take) begin
        if (pie_en_q)
          vec_q <= SRC_BASE + ((ADDR_W'(line_sel) * PER_GRP_A + ADDR_W'(sel_idx)) << 1);
        else
          vec_q <= LINE_BASE + ((ADDR_W'(line_sel) + 1'b1) << 1);
      end
    end
  end

  gie_ctx_seq #(.STEPS(CTX_STEPS), .SEL_W(SEL_W)) u_ctx (
    .clk(clk), .rst_n(rst_n), .start(take), .ready(ctx_ready),
    .valid(busy), .sel(ctx_sel)
  );

  assign ctx_valid = busy;
  assign vec_valid = busy;
  assign vec_addr  = vec_q;

  AST_TAKE_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> gmask_q && !cpu_irq); // R7
  AST_TAKE_ACKS_GRP: assert property (@(posedge clk) disable iff (!rst_n)
    take && pie_en_q |=> grp_ack[$past(line_sel)]); // R6
  AST_LINE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !line_flag_q[$past(line_sel)]); // R6
  AST_VEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid && $past(vec_valid) |-> $stable(vec_addr)); // R5
endmodule

// File: tb/grp_irq_expander_tb_top.sv
`timescale 1ns/1ps
module grp_irq_expander_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [95:0] irq_req = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_kind = '0;
  logic [3:0]  wr_grp = '0;
  logic [11:0] wr_data = '0;
  logic        cpu_ack = 1'b0;
  logic        ctx_ready = 1'b0;
  logic        cpu_irq, vec_valid, ctx_valid;
  logic [21:0] vec_addr;
  logic [2:0]  ctx_sel;
  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  grp_irq_expander dut_i (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .wr_en(wr_en), .wr_kind(wr_kind),
    .wr_grp(wr_grp), .wr_data(wr_data), .cpu_ack(cpu_ack), .cpu_irq(cpu_irq),
    .vec_valid(vec_valid), .vec_addr(vec_addr), .ctx_valid(ctx_valid),
    .ctx_ready(ctx_ready), .ctx_sel(ctx_sel)
  );

  // source id, expected vector (expander enabled)
  localparam logic [6:0]  TBL_SRC [6] = '{7'd0, 7'd7, 7'd13, 7'd50, 7'd88, 7'd95};
  localparam logic [21:0] TBL_VEC [6] = '{22'h000D00, 22'h000D0E, 22'h000D1A,
                                          22'h000D64, 22'h000DB0, 22'h000DBE};

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", r, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] k, input int g, input logic [11:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_kind = k; wr_grp = 4'(g); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse(input int s);
    irq_req[s] = 1'b1;
    @(negedge clk);
    irq_req[s] = 1'b0;
  endtask

  task automatic take_it();
    cpu_ack = 1'b1;
    @(negedge clk);
    cpu_ack = 1'b0;
  endtask

  task automatic drain();
    for (int s = 0; s < 7; s++) begin
      chk("R8 valid", ctx_valid, 1);
      chk("R8 order", ctx_sel, s);
      ctx_ready = 1'b1;
      @(negedge clk);
      ctx_ready = 1'b0;
    end
    chk("R8 end", ctx_valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 irq", cpu_irq, 0);
    chk("R1 ctx", ctx_valid, 0);
    chk("R1 vec", vec_valid, 0);
    // mask set from reset: no request reaches the CPU
    wr(3'd2, 0, 12'hFFF);
    wr(3'd0, 0, 12'h001);
    pulse(0);
    @(negedge clk);
    chk("R1 mask", cpu_irq, 0);

    // table walk over sources in different groups
    for (int e = 0; e < 6; e++) begin
      int s, g, i;
      s = int'(TBL_SRC[e]); g = s / 8; i = s % 8;
      wr(3'd4, 0, 12'h001);
      wr(3'd0, g, 12'(1 << i));
      pulse(s);
      @(negedge clk);
      chk("R3 irq", cpu_irq, 1);
      take_it();
      chk("R5 valid", vec_valid, 1);
      chk("R5 vec", vec_addr, TBL_VEC[e]);
      chk("R7 masked", cpu_irq, 0);
      drain();
      wr(3'd1, 0, 12'(1 << g));
      wr(3'd0, g, 12'h000);
    end

    // priority across lines and within a group
    wr(3'd4, 0, 12'h001);
    wr(3'd0, 0, 12'h008);
    wr(3'd0, 2, 12'h012);
    irq_req[3] = 1'b1; irq_req[17] = 1'b1; irq_req[20] = 1'b1;
    @(negedge clk);
    irq_req[3] = 1'b0; irq_req[17] = 1'b0; irq_req[20] = 1'b0;
    @(negedge clk);
    take_it();
    chk("R4 line", vec_addr, 22'h000D06);
    repeat (3) @(negedge clk);
    chk("R8 hold", ctx_sel, 0);
    chk("R8 hold valid", ctx_valid, 1);
    chk("R5 hold", vec_addr, 22'h000D06);
    drain();
    chk("R7 still masked", cpu_irq, 0);
    wr(3'd4, 0, 12'h001);
    chk("R7 unmask", cpu_irq, 1);
    take_it();
    chk("R4 index", vec_addr, 22'h000D22);
    drain();
    wr(3'd4, 0, 12'h001);
    chk("R6 group blocked", cpu_irq, 0);
    wr(3'd1, 0, 12'h005);
    @(negedge clk);
    chk("R6 released", cpu_irq, 1);
    take_it();
    chk("R4 next", vec_addr, 22'h000D28);
    drain();
    wr(3'd1, 0, 12'h005);
    wr(3'd0, 0, 12'h000);
    wr(3'd0, 2, 12'h000);

    // request held high across the take: set beats clear
    wr(3'd4, 0, 12'h001);
    wr(3'd0, 0, 12'h020);
    irq_req[5] = 1'b1;
    repeat (2) @(negedge clk);
    chk("R2 irq", cpu_irq, 1);
    take_it();
    chk("R2 vec", vec_addr, 22'h000D0A);
    drain();
    irq_req[5] = 1'b0;
    wr(3'd1, 0, 12'h001);
    wr(3'd4, 0, 12'h001);
    chk("R2 flag kept", cpu_irq, 1);
    take_it();
    chk("R2 vec again", vec_addr, 22'h000D0A);
    drain();
    wr(3'd1, 0, 12'h001);
    wr(3'd0, 0, 12'h000);

    // expander disabled: line vector, source stays pending
    wr(3'd4, 0, 12'h000);
    wr(3'd0, 1, 12'h002);
    pulse(9);
    @(negedge clk);
    chk("R3 disabled irq", cpu_irq, 1);
    take_it();
    chk("R5 line vec", vec_addr, 22'h3FFFC4);
    drain();
    wr(3'd4, 0, 12'h001);
    chk("R10 still pending", cpu_irq, 1);
    take_it();
    chk("R10 src vec", vec_addr, 22'h000D12);
    drain();
    wr(3'd1, 0, 12'h002);
    wr(3'd0, 1, 12'h000);

    // line enable and flag clears
    wr(3'd4, 0, 12'h001);
    wr(3'd0, 3, 12'h001);
    wr(3'd2, 0, 12'hFF7);
    pulse(24);
    @(negedge clk);
    chk("R9 line disabled", cpu_irq, 0);
    wr(3'd5, 3, 12'h001);
    wr(3'd3, 0, 12'h008);
    wr(3'd2, 0, 12'hFFF);
    @(negedge clk);
    chk("R9 flags cleared", cpu_irq, 0);

    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      done = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule